// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus that is compatible with SMBus. It holds a bank of byte-wide configuration registers and drives them out to the rest of the device. A fast system clock samples the serial clock and data lines. The data line is open-drain: the block only ever pulls it low, and it releases the line every other time. After an address match, the bus master can use four kinds of transfer: a single byte write, a single byte read, a block write and a block read.

The top bit of the command byte chooses the kind of transfer. When that bit is 1, the lower seven bits give the offset of one register. When that bit is 0, the transfer is a block transfer. A block transfer always starts at offset 0 and carries a byte count. On a block write, the master sends the count. On a block read, the slave returns the count, taken from a dedicated count register, and that count also sets how many register bytes follow it.

At reset, each register loads a default value from a parameter. Bits named in a strap mask load from the strap input instead. A stop or a start that arrives in the middle of a byte abandons the transfer without changing any register.

Top module: `cfgslv_top`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2, which is 7-bit address 0x69 with the write bit, or 0xD3 for a read. Any other address byte is not acknowledged, and the rest of that transfer changes nothing.
- R2: Out of reset, register i holds the bits of DEFAULTS[8i+7:8i] where STRAP_MASK is 0, and the bits of strap_i[8i+7:8i] where STRAP_MASK is 1. The data line is released.
- R3: A byte write uses a command byte with bit 7 = 1, and its bits 6:0 give the offset. The next byte is stored at that offset. Any further bytes in the same transfer are acknowledged but not stored.
- R4: A byte read sends the address with the write bit, a command byte with bit 7 = 1, a repeated start, and the address with the read bit. The slave then returns the register at that offset, most significant bit first.
- R5: A block write uses command 0x00, then a count byte N, then data bytes. The first N data bytes go to offsets 0, 1, 2 and so on. Data bytes beyond N are acknowledged and dropped.
- R6: A block read first returns the value C of the count register (offset 8, reset value 0x0F). It then returns offsets 0 to C-1 in order. Every byte after those reads 0xFF.
- R7: A read of an offset at or above NUM_REGS returns 0xFF, and a write to such an offset changes no register.
- R8: A start or stop condition that arrives before all 8 bits of a byte have been clocked in leaves every register unchanged. A stop always releases the data line.
- R9: The slave pulls the data line low only for an acknowledge or for a 0 data bit. It changes the data line only while the serial clock is low. An acknowledge is held from the falling edge of the 8th clock to the falling edge of the 9th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | NUM_REGS*8 | Strap values loaded at reset where STRAP_MASK is set |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| cfg_o | output | NUM_REGS*8 | Register contents; register i is at bits 8i+7:8i |

## Verification
Every register is visible on cfg_o one cycle after its write, so a wrong pointer or a wrong byte-count state shows up as a corrupted register within one byte time of the faulty transfer. If the phase or the bit count is wrong, an acknowledge moves into the wrong bit slot. The master sees that at the very next 9th clock as a missing acknowledge, or it sees a shifted read value. A read pointer or read count that runs ahead of its limit shows up as a data byte where 0xFF is due, or 0xFF where data is due, at the end of a block read.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_WCNT,
      PH_WDATA,
      PH_TX,
      PH_SKIP
   } phase_t;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda;
   } line_ev_t;

   localparam logic [7:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/cfgslv_line_mon.sv
module cfgslv_line_mon
   import cfgslv_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_in,
   input  logic     sda_in,
   output logic     scl_lvl,
   output line_ev_t ev
);

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_c, sda_c, scl_p, sda_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      end
   end

   generate
      if (FILTER_EN) begin : g_filt
         logic scl_f, sda_f;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               scl_f <= 1'b1;
               sda_f <= 1'b1;
            end else begin
               if (scl_sh[SYNC_STAGES-1] == scl_sh[SYNC_STAGES-2]) scl_f <= scl_sh[SYNC_STAGES-1];
               if (sda_sh[SYNC_STAGES-1] == sda_sh[SYNC_STAGES-2]) sda_f <= sda_sh[SYNC_STAGES-1];
            end
         end
         assign scl_c = scl_f;
         assign sda_c = sda_f;
      end else begin : g_raw
         assign scl_c = scl_sh[SYNC_STAGES-1];
         assign sda_c = sda_sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_c;
         sda_p <= sda_c;
      end
   end

   always_comb begin
      ev.scl_rise = scl_c & ~scl_p;
      ev.scl_fall = ~scl_c & scl_p;
      ev.start    = scl_c & scl_p & sda_p & ~sda_c;
      ev.stop     = scl_c & scl_p & ~sda_p & sda_c;
      ev.sda      = sda_c;
   end

   assign scl_lvl = scl_c;

endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank #(
   parameter int                     NUM_REGS   = 16,
   parameter logic [NUM_REGS*8-1:0]  DEFAULTS   = '0,
   parameter logic [NUM_REGS*8-1:0]  STRAP_MASK = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_REGS*8-1:0]   strap_in,
   input  logic                    wr_en,
   input  logic [6:0]              wr_idx,
   input  logic [7:0]              wr_data,
   input  logic [6:0]              rd_idx,
   output logic [7:0]              rd_data,
   output logic [NUM_REGS*8-1:0]   regs_flat
);

   logic [7:0] q [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               q[i] <= (DEFAULTS[i*8 +: 8] & ~STRAP_MASK[i*8 +: 8]) |
                       (strap_in[i*8 +: 8] & STRAP_MASK[i*8 +: 8]);
            else if (wr_en && (wr_idx == 7'(i)))
               q[i] <= wr_data;
         end
         assign regs_flat[i*8 +: 8] = q[i];
      end
   endgenerate

   always_comb begin
      rd_data = 8'hFF;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_idx == 7'(k)) rd_data = q[k];
   end

endmodule

// File: rtl/cfgslv_ctrl.sv
module cfgslv_ctrl
   import cfgslv_pkg::*;
#(
   parameter logic [6:0] ADDR7    = 7'h69,
   parameter int         NUM_REGS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  line_ev_t   ev,
   input  logic [7:0] rd_data,
   input  logic [7:0] bc_val,
   output logic       sda_low,
   output logic       wr_en,
   output logic [6:0] wr_idx,
   output logic [7:0] wr_data,
   output logic [6:0] rd_idx
);

   phase_t     ph;
   logic [3:0] cnt;
   logic       ackph, blk, rd_req, mack;
   logic [7:0] sh, wrem, rrem;
   logic [6:0] ptr;
   logic       byte_done;
   logic [7:0] nxt_tx, first_tx;
   logic [6:0] ptr_inc;

   assign byte_done = ev.scl_fall && !ackph && (cnt == 4'd8) && !ev.start && !ev.stop;
   assign wr_en     = byte_done && (ph == PH_WDATA) && (wrem != 8'd0) &&
                      ({1'b0, ptr} < 8'(NUM_REGS));
   assign wr_idx    = ptr;
   assign wr_data   = sh;
   assign rd_idx    = ptr;
   assign ptr_inc   = (ptr == 7'h7F) ? ptr : ptr + 7'd1;
   assign nxt_tx    = (rrem != 8'd0) ? rd_data : IDLE_BYTE;
   assign first_tx  = blk ? bc_val : rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph <= PH_IDLE; cnt <= '0; ackph <= 1'b0; sda_low <= 1'b0;
         blk <= 1'b0; rd_req <= 1'b0; mack <= 1'b0;
         sh <= '0; wrem <= '0; rrem <= '0; ptr <= '0;
      end else if (ev.start) begin
         ph <= PH_ADDR; cnt <= '0; ackph <= 1'b0; sda_low <= 1'b0;
      end else if (ev.stop) begin
         ph <= PH_IDLE; cnt <= '0; ackph <= 1'b0; sda_low <= 1'b0;
      end else if (ph == PH_TX) begin
         if (ev.scl_rise) begin
            if (ackph) mack <= ~ev.sda;
            else       cnt  <= cnt + 4'd1;
         end else if (ev.scl_fall) begin
            if (ackph) begin
               ackph <= 1'b0;
               cnt   <= '0;
               if (mack) begin
                  sh      <= nxt_tx;
                  sda_low <= ~nxt_tx[7];
                  if (rrem != 8'd0) begin
                     ptr  <= ptr_inc;
                     rrem <= rrem - 8'd1;
                  end
               end else begin
                  ph      <= PH_SKIP;
                  sda_low <= 1'b0;
               end
            end else if (cnt == 4'd8) begin
               ackph   <= 1'b1;
               sda_low <= 1'b0;
            end else begin
               sh      <= {sh[6:0], 1'b0};
               sda_low <= ~sh[6];
            end
         end
      end else if (ph != PH_IDLE && ph != PH_SKIP) begin
         if (ev.scl_rise && !ackph && cnt != 4'd8) begin
            sh  <= {sh[6:0], ev.sda};
            cnt <= cnt + 4'd1;
         end else if (byte_done) begin
            cnt <= '0;
            unique case (ph)
               PH_ADDR: begin
                  if (sh[7:1] == ADDR7) begin
                     sda_low <= 1'b1;
                     ackph   <= 1'b1;
                     rd_req  <= sh[0];
                  end else begin
                     ph <= PH_SKIP;
                  end
               end
               PH_CMD: begin
                  sda_low <= 1'b1;
                  ackph   <= 1'b1;
                  blk     <= ~sh[7];
                  ptr     <= sh[7] ? sh[6:0] : 7'd0;
                  wrem    <= sh[7] ? 8'd1 : 8'd0;
               end
               PH_WCNT: begin
                  sda_low <= 1'b1;
                  ackph   <= 1'b1;
                  wrem    <= sh;
               end
               default: begin
                  sda_low <= 1'b1;
                  ackph   <= 1'b1;
                  if (wrem != 8'd0) begin
                     wrem <= wrem - 8'd1;
                     ptr  <= ptr_inc;
                  end
               end
            endcase
         end else if (ev.scl_fall && ackph) begin
            ackph   <= 1'b0;
            cnt     <= '0;
            sda_low <= 1'b0;
            unique case (ph)
               PH_ADDR: begin
                  if (rd_req) begin
                     ph      <= PH_TX;
                     sh      <= first_tx;
                     sda_low <= ~first_tx[7];
                     rrem    <= blk ? bc_val : 8'd0;
                  end else begin
                     ph <= PH_CMD;
                  end
               end
               PH_CMD:  ph <= blk ? PH_WCNT : PH_WDATA;
               PH_WCNT: ph <= PH_WDATA;
               default: ph <= PH_WDATA;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top
   import cfgslv_pkg::*;
#(
   parameter int                    NUM_REGS    = 16,
   parameter logic [6:0]            ADDR7       = 7'h69,
   parameter int                    BC_IDX      = 8,
   parameter int                    SYNC_STAGES = 2,
   parameter bit                    FILTER_EN   = 1'b1,
   parameter logic [NUM_REGS*8-1:0] DEFAULTS    = 128'h00A0_A0B4_B500_E10F_1855_1000_C0BE_FA00,
   parameter logic [NUM_REGS*8-1:0] STRAP_MASK  = 128'h0000_0000_0000_0000_0000_0028_0000_0017
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic [NUM_REGS*8-1:0] strap_i,
   output logic                  sda_pull_o,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > 128) begin : g_bad_regs
         $error("cfgslv_top: NUM_REGS must lie in 1..128");
      end
      if (BC_IDX < 0 || BC_IDX >= NUM_REGS) begin : g_bad_bc
         $error("cfgslv_top: BC_IDX must address an implemented register");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cfgslv_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   line_ev_t   ev;
   logic       scl_lvl;
   logic       wr_en;
   logic [6:0] wr_idx, rd_idx;
   logic [7:0] wr_data, rd_data, bc_val;

   cfgslv_line_mon #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILTER_EN  (FILTER_EN)
   ) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_in (scl_i),
      .sda_in (sda_i),
      .scl_lvl(scl_lvl),
      .ev     (ev)
   );

   cfgslv_ctrl #(
      .ADDR7   (ADDR7),
      .NUM_REGS(NUM_REGS)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .rd_data(rd_data),
      .bc_val (bc_val),
      .sda_low(sda_pull_o),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .rd_idx (rd_idx)
   );

   cfgslv_regbank #(
      .NUM_REGS  (NUM_REGS),
      .DEFAULTS  (DEFAULTS),
      .STRAP_MASK(STRAP_MASK)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_in (strap_i),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .regs_flat(cfg_o)
   );

   assign bc_val = cfg_o[BC_IDX*8 +: 8];

endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk #(
   parameter int NUM_REGS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  stop_s,
   input logic                  sda_pull,
   input logic                  wr_en,
   input logic [6:0]            wr_idx,
   input logic [7:0]            wr_data,
   input logic [NUM_REGS*8-1:0] cfg
);

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !$past(scl_s)); // R9

   AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_idx} < 8'(NUM_REGS))); // R7

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_s |=> !sda_pull); // R8

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cfg[int'($past(wr_idx))*8 +: 8] == $past(wr_data))); // R3

endmodule

bind cfgslv_top cfgslv_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_s   (scl_lvl),
   .stop_s  (ev.stop),
   .sda_pull(sda_pull_o),
   .wr_en   (wr_en),
   .wr_idx  (wr_idx),
   .wr_data (wr_data),
   .cfg     (cfg_o)
);

// File: tb/cfgslv_top_tb_top.sv
module cfgslv_top_tb_top;

   localparam int N = 16;
   localparam logic [N*8-1:0] DEF  = 128'h00A0_A0B4_B500_E10F_1855_1000_C0BE_FA00;
   localparam logic [N*8-1:0] MASK = 128'h0000_0000_0000_0000_0000_0028_0000_0017;
   localparam logic [N*8-1:0] STRAP = {88'h0, 8'h08, 24'h0, 8'hFF};

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull;
   logic [N*8-1:0] cfg;
   wire  sda_line = sda_m & ~sda_pull;

   cfgslv_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .strap_i   (STRAP),
      .sda_pull_o(sda_pull),
      .cfg_o     (cfg)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] mdl [N];
   logic [7:0] rbuf [24];
   logic [7:0] wbuf [24];
   logic [7:0] cnt_byte;
   bit ackv;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [N*8-1:0] mdl_flat();
      logic [N*8-1:0] f;
      for (int i = 0; i < N; i++) f[i*8 +: 8] = mdl[i];
      return f;
   endfunction

   task automatic chk_cfg(input string req);
      checks++;
      if (cfg !== mdl_flat()) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, cfg, mdl_flat());
      end
   endtask

   task automatic hp();
      repeat (8) @(negedge clk);
   endtask

   task automatic clk_bit(input bit v, output bit r);
      sda_m = v; hp();
      scl_m = 1'b1; hp();
      r = sda_line;
      scl_m = 1'b0; hp();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hp();
      scl_m = 1'b1; hp();
      sda_m = 1'b0; hp();
      scl_m = 1'b0; hp();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hp();
      scl_m = 1'b1; hp();
      sda_m = 1'b1; hp();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      bit r;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
      clk_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] b);
      bit r;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, r);
         b[i] = r;
      end
      clk_bit(nack, r);
   endtask

   task automatic wr_byte(input logic [7:0] off, input logic [7:0] d);
      bit a0, a1, a2;
      bus_start();
      send_byte(8'hD2, a0);
      send_byte(8'h80 | off, a1);
      send_byte(d, a2);
      bus_stop();
      chk("R1 byte write acks", {a0, a1, a2}, 3'b111);
      if (off < N) mdl[off] = d;
   endtask

   task automatic rd_byte(input logic [7:0] off, output logic [7:0] d);
      bit a0, a1, a2;
      bus_start();
      send_byte(8'hD2, a0);
      send_byte(8'h80 | off, a1);
      bus_start();
      send_byte(8'hD3, a2);
      recv_byte(1'b1, d);
      bus_stop();
      chk("R1 byte read acks", {a0, a1, a2}, 3'b111);
   endtask

   task automatic blk_wr(input int cnt, input int nsend);
      bit a;
      int acks = 0;
      bus_start();
      send_byte(8'hD2, a); acks += a;
      send_byte(8'h00, a); acks += a;
      send_byte(8'(cnt), a); acks += a;
      for (int i = 0; i < nsend; i++) begin
         send_byte(wbuf[i], a); acks += a;
         if (i < cnt && i < N) mdl[i] = wbuf[i];
      end
      bus_stop();
      chk("R5 block write acks every byte", acks, nsend + 3);
   endtask

   task automatic blk_rd(input int n);
      bit a0, a1, a2;
      bus_start();
      send_byte(8'hD2, a0);
      send_byte(8'h00, a1);
      bus_start();
      send_byte(8'hD3, a2);
      recv_byte(n == 0, cnt_byte);
      for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
      bus_stop();
      chk("R1 block read acks", {a0, a1, a2}, 3'b111);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      bit a;
      void'($urandom(32'd2024));
      for (int i = 0; i < N; i++)
         mdl[i] = (DEF[i*8 +: 8] & ~MASK[i*8 +: 8]) | (STRAP[i*8 +: 8] & MASK[i*8 +: 8]);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2: reset contents and released line
      chk_cfg("R2 reset contents");
      chk("R2 strap merge reg0", cfg[7:0], 8'h17);
      chk("R2 line released", sda_pull, 0);

      // R1: foreign address ignored
      bus_start();
      send_byte(8'hA4, a);
      chk("R1 foreign address nack", a, 0);
      send_byte(8'h85, a);
      send_byte(8'h5A, a);
      bus_stop();
      chk_cfg("R1 foreign address no effect");

      // R3 / R4: byte write and read back
      wr_byte(8'd5, 8'h3C);
      chk_cfg("R3 byte write stored");
      rd_byte(8'd5, d);
      chk("R4 byte read offset 5", d, 8'h3C);
      rd_byte(8'd0, d);
      chk("R4 byte read strap reg", d, 8'h17);

      // R3: extra bytes after byte write dropped
      begin
         bit x;
         bus_start();
         send_byte(8'hD2, x);
         send_byte(8'h86, x);
         send_byte(8'h11, x);
         send_byte(8'h22, x);
         chk("R3 extra byte acked", x, 1);
         bus_stop();
         mdl[6] = 8'h11;
         chk_cfg("R3 extra byte not stored");
      end

      // R7: out-of-range offset
      wr_byte(8'd20, 8'h99);
      chk_cfg("R7 out-of-range write ignored");
      rd_byte(8'd20, d);
      chk("R7 out-of-range read", d, 8'hFF);

      // R5: block write, exact count then over-long
      for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
      blk_wr(4, 4);
      chk_cfg("R5 block write 4");
      for (int i = 0; i < 4; i++) wbuf[i] = 8'h60 + 8'(i);
      blk_wr(2, 4);
      chk_cfg("R5 block write bytes past count dropped");

      // R6: block read with default count
      blk_rd(16);
      chk("R6 count byte default", cnt_byte, 8'h0F);
      begin
         int bad = 0;
         for (int i = 0; i < 15; i++) if (rbuf[i] !== mdl[i]) bad++;
         chk("R6 block read data offsets 0..14", bad, 0);
      end
      chk("R6 byte past count", rbuf[15], 8'hFF);

      // R6: shortened count
      wr_byte(8'd8, 8'd3);
      blk_rd(5);
      chk("R6 count byte 3", cnt_byte, 8'd3);
      chk("R6 short read off0", rbuf[0], mdl[0]);
      chk("R6 short read off2", rbuf[2], mdl[2]);
      chk("R6 short read past count", rbuf[3], 8'hFF);
      chk("R9 released after read", sda_pull, 0);

      // R8: start in mid-byte aborts
      begin
         bit x, r;
         bus_start();
         send_byte(8'hD2, x);
         send_byte(8'h8A, x);
         for (int i = 0; i < 5; i++) clk_bit(1'b1, r);
         bus_start();
         send_byte(8'hD2, x);
         send_byte(8'h8B, x);
         for (int i = 0; i < 3; i++) clk_bit(1'b0, r);
         bus_stop();
         chk_cfg("R8 mid-byte start and stop leave registers");
         chk("R8 stop releases line", sda_pull, 0);
      end

      // R9: ack seen in the 9th clock, line free afterwards
      bus_start();
      send_byte(8'hD2, a);
      chk("R9 ack low in 9th clock", a, 1);
      bus_stop();
      chk("R9 released after stop", sda_pull, 0);

      // Random byte writes and reads (R3, R4)
      for (int it = 0; it < 30; it++) begin
         logic [7:0] off, dv, ro;
         off = 8'($urandom_range(0, N - 1));
         if (off == 8'd8) off = 8'd9;
         dv  = 8'($urandom);
         wr_byte(off, dv);
         chk_cfg("R3 random write");
         ro = 8'($urandom_range(0, N + 3));
         rd_byte(ro, d);
         chk("R4 random read", d, (ro < N) ? mdl[ro] : 8'hFF);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule